// File: doc/BRIEF.md
# Multi-Port Read-Claim Semaphore

This block is a one-bit hardware lock that several independent bus hosts share, so that only one of them at a time uses a common peripheral. Each host has its own access port into a small register space. One address in that space holds the lock bit.

A plain read of that address does the locking: if the lock is free, the read returns 0 and the same access claims the lock. While the lock is held, every read returns 1 and changes nothing. A host gives the lock back by writing a word whose bit 0 is 1. Any port may release the lock, including one that does not own it, so that software can always recover a lock that was left held. The index of the owning port is shown on a status output.

Each port issues at most one access per cycle and is never stalled: the block has no ready signal and accepts every request in the cycle it is presented. Read results come back as a registered `rd_valid`/`rd_data` pair one cycle after the request. The reader cannot push back on them, so it must take the result in that cycle.

Top module: `sema_lock`

## Requirements
- R1: After reset the lock is free: `lock_held` is 0, `lock_owner` is 0, every `rd_valid` bit is 0 and every `rd_data` word is 0.
- R2: A read of the lock address (`LOCK_ADDR`, default 8) while the lock is free returns the word 0 on the next cycle. From that cycle on, `lock_held` is 1 and `lock_owner` is the reading port.
- R3: A read of the lock address while the lock is held returns the word 1 (only bit 0 set) on the next cycle, and `lock_held` and `lock_owner` keep their values.
- R4: When several ports read the free lock in the same cycle, only the lowest-numbered of them gets 0 and becomes owner; every other reader in that cycle gets 1.
- R5: A write to the lock address with `acc_wbit` = 1 frees a held lock on the next cycle (`lock_held` 0, `lock_owner` 0), whichever port issues it.
- R6: A write to the lock address with `acc_wbit` = 0 has no effect on the lock or its owner.
- R7: An access to any other address neither claims nor releases the lock. A read there returns the word 0.
- R8: All accesses in one cycle are judged against the lock state at the start of that cycle. If the lock is held and a release and a lock read arrive together, the reader gets 1 and the lock is free afterwards. If the lock is free, a release in the same cycle as a claiming read is ignored and the claim stands.
- R9: `rd_valid[i]` is 1 in exactly the cycle after port i issued a read, and 0 otherwise. Writes never raise it. `rd_data[i]` is 0 whenever `rd_valid[i]` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_en | input | N_PORTS | Per-port access request for this cycle |
| acc_wr | input | N_PORTS | Per-port direction: 1 write, 0 read |
| acc_addr | input | N_PORTS x ADDR_W | Per-port register address |
| acc_wbit | input | N_PORTS | Per-port bit 0 of the write word (the only write bit the block uses) |
| rd_valid | output | N_PORTS | Per-port read result valid, one cycle after the read |
| rd_data | output | N_PORTS x DATA_W | Per-port read word; bit 0 is the lock reply, upper bits 0 |
| lock_held | output | 1 | Lock currently claimed |
| lock_owner | output | clog2(N_PORTS) | Index of the owning port, 0 while free |

## Verification
The assertions assume that a port's `acc_wr`, `acc_addr` and `acc_wbit` matter only in cycles where its `acc_en` is high. They also assume that the host takes every read result in the cycle it appears, since the result interface has no back-pressure. The bench holds to both: each port does exactly one kind of access or stays idle in a cycle, and inputs change only on the falling clock edge. It sweeps every mix of access kinds over four ports, starting from a free lock and from a lock held by each port.

// File: rtl/sema_pkg.sv
package sema_pkg;
  // width of a port index for n ports (never below one bit)
  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/sema_port_decode.sv
module sema_port_decode #(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned LOCK_ADDR = 8
) (
  input  logic              en,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wbit,
  output logic              lock_rd,
  output logic              plain_rd,
  output logic              rel_req
);
  logic hit;

  assign hit      = (addr == ADDR_W'(LOCK_ADDR));
  assign lock_rd  = en & ~wr & hit;
  assign plain_rd = en & ~wr & ~hit;
  assign rel_req  = en & wr & hit & wbit;
endmodule

// File: rtl/sema_prio_pick.sv
module sema_prio_pick #(
  parameter int unsigned N     = 4,
  parameter int unsigned IDX_W = 2
) (
  input  logic [N-1:0]     req,
  output logic [N-1:0]     grant,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  // scan from the top down so the lowest requester is the last to overwrite
  always_comb begin
    grant = '0;
    idx   = '0;
    any   = 1'b0;
    for (int i = int'(N) - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        idx      = IDX_W'(i);
        any      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sema_lock_state.sv
module sema_lock_state #(
  parameter int unsigned IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             claim_any,
  input  logic [IDX_W-1:0] claim_idx,
  input  logic             release_any,
  output logic             held,
  output logic [IDX_W-1:0] owner
);
  // a claim can only land on a free lock, a release only on a held one
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held  <= 1'b0;
      owner <= '0;
    end else if (held) begin
      if (release_any) begin
        held  <= 1'b0;
        owner <= '0;
      end
    end else if (claim_any) begin
      held  <= 1'b1;
      owner <= claim_idx;
    end
  end
endmodule

// File: rtl/sema_lock.sv
module sema_lock
  import sema_pkg::*;
#(
  parameter int unsigned N_PORTS   = 4,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned LOCK_ADDR = 8,
  localparam int unsigned IDX_W    = idx_width(N_PORTS)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [N_PORTS-1:0]             acc_en,
  input  logic [N_PORTS-1:0]             acc_wr,
  input  logic [N_PORTS-1:0][ADDR_W-1:0] acc_addr,
  input  logic [N_PORTS-1:0]             acc_wbit,
  output logic [N_PORTS-1:0]             rd_valid,
  output logic [N_PORTS-1:0][DATA_W-1:0] rd_data,
  output logic                           lock_held,
  output logic [IDX_W-1:0]               lock_owner
);
  logic [N_PORTS-1:0] lock_rd;
  logic [N_PORTS-1:0] plain_rd;
  logic [N_PORTS-1:0] rel_req;
  logic [N_PORTS-1:0] grant;
  logic [IDX_W-1:0]   win_idx;
  logic               win_any;
  logic               claim_any;

  for (genvar g = 0; g < N_PORTS; g++) begin : g_port
    sema_port_decode #(
      .ADDR_W   (ADDR_W),
      .LOCK_ADDR(LOCK_ADDR)
    ) u_dec (
      .en      (acc_en[g]),
      .wr      (acc_wr[g]),
      .addr    (acc_addr[g]),
      .wbit    (acc_wbit[g]),
      .lock_rd (lock_rd[g]),
      .plain_rd(plain_rd[g]),
      .rel_req (rel_req[g])
    );
  end

  sema_prio_pick #(
    .N    (N_PORTS),
    .IDX_W(IDX_W)
  ) u_pick (
    .req  (lock_rd),
    .grant(grant),
    .idx  (win_idx),
    .any  (win_any)
  );

  assign claim_any = win_any & ~lock_held;

  sema_lock_state #(
    .IDX_W(IDX_W)
  ) u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .claim_any  (claim_any),
    .claim_idx  (win_idx),
    .release_any(|rel_req),
    .held       (lock_held),
    .owner      (lock_owner)
  );

  // read replies: 0 only for the single winner of a free lock
  logic [N_PORTS-1:0]             nxt_valid;
  logic [N_PORTS-1:0][DATA_W-1:0] nxt_data;

  always_comb begin
    for (int i = 0; i < int'(N_PORTS); i++) begin
      nxt_valid[i]   = lock_rd[i] | plain_rd[i];
      nxt_data[i]    = '0;
      nxt_data[i][0] = lock_rd[i] & (lock_held | ~grant[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= '0;
      rd_data  <= '0;
    end else begin
      rd_valid <= nxt_valid;
      rd_data  <= nxt_data;
    end
  end
endmodule

// File: rtl/sema_lock_chk.sv
module sema_lock_chk #(
  parameter int unsigned N_PORTS   = 4,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned LOCK_ADDR = 8,
  parameter int unsigned IDX_W     = 2
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic [N_PORTS-1:0]             acc_en,
  input logic [N_PORTS-1:0]             acc_wr,
  input logic [N_PORTS-1:0][ADDR_W-1:0] acc_addr,
  input logic [N_PORTS-1:0]             acc_wbit,
  input logic [N_PORTS-1:0]             rd_valid,
  input logic [N_PORTS-1:0][DATA_W-1:0] rd_data,
  input logic                           lock_held,
  input logic [IDX_W-1:0]               lock_owner
);
  logic [N_PORTS-1:0] c_lock_rd;
  logic [N_PORTS-1:0] c_any_rd;
  logic               c_rel;
  logic [N_PORTS-1:0] prev_lock_rd;
  logic [N_PORTS-1:0] prev_any_rd;
  logic [N_PORTS-1:0] zero_seen;

  always_comb begin
    c_rel = 1'b0;
    for (int i = 0; i < int'(N_PORTS); i++) begin
      c_any_rd[i]  = acc_en[i] && !acc_wr[i];
      c_lock_rd[i] = c_any_rd[i] && (acc_addr[i] == ADDR_W'(LOCK_ADDR));
      if (acc_en[i] && acc_wr[i] && acc_wbit[i] &&
          (acc_addr[i] == ADDR_W'(LOCK_ADDR)))
        c_rel = 1'b1;
      zero_seen[i] = rd_valid[i] && prev_lock_rd[i] && !rd_data[i][0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_lock_rd <= '0;
      prev_any_rd  <= '0;
    end else begin
      prev_lock_rd <= c_lock_rd;
      prev_any_rd  <= c_any_rd;
    end
  end

  // R1
  free_owner_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_held |-> lock_owner == '0);

  // R2
  claim_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_held && (|c_lock_rd)) |=> lock_held);

  // R3
  hold_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_held && !c_rel) |=> (lock_held && $stable(lock_owner)));

  // R4
  single_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(zero_seen) <= 1);

  // R5
  release_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_held && c_rel) |=> !lock_held);

  // R9
  valid_tracks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid == prev_any_rd);
endmodule

bind sema_lock sema_lock_chk #(
  .N_PORTS  (N_PORTS),
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .LOCK_ADDR(LOCK_ADDR),
  .IDX_W    (IDX_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_en    (acc_en),
  .acc_wr    (acc_wr),
  .acc_addr  (acc_addr),
  .acc_wbit  (acc_wbit),
  .rd_valid  (rd_valid),
  .rd_data   (rd_data),
  .lock_held (lock_held),
  .lock_owner(lock_owner)
);

// File: tb/sim_sema_lock.sv
module sim_sema_lock;
  localparam int NP = 4;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int LA = 8;
  localparam int OA = 4;
  localparam int IW = 2;

  // per-port access kinds
  localparam int K_IDLE = 0;
  localparam int K_LRD  = 1;
  localparam int K_PRD  = 2;
  localparam int K_REL  = 3;
  localparam int K_WZ   = 4;
  localparam int K_WO   = 5;

  logic                   clk;
  logic                   rst_n;
  logic [NP-1:0]          acc_en;
  logic [NP-1:0]          acc_wr;
  logic [NP-1:0][AW-1:0]  acc_addr;
  logic [NP-1:0]          acc_wbit;
  logic [NP-1:0]          rd_valid;
  logic [NP-1:0][DW-1:0]  rd_data;
  logic                   lock_held;
  logic [IW-1:0]          lock_owner;

  int n_cmp  = 0;
  int n_fail = 0;
  bit done   = 0;

  bit      m_held  = 0;
  int      m_owner = 0;

  sema_lock #(
    .N_PORTS(NP), .ADDR_W(AW), .DATA_W(DW), .LOCK_ADDR(LA)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
    .acc_addr(acc_addr), .acc_wbit(acc_wbit), .rd_valid(rd_valid),
    .rd_data(rd_data), .lock_held(lock_held), .lock_owner(lock_owner)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  endtask

  // one access cycle; called at a falling edge, returns at the next one
  task automatic cyc(input int k0, input int k1, input int k2, input int k3, input string tag);
    int kd[NP];
    bit any_rel;
    int win;
    int ev[NP];
    int ed[NP];
    kd[0] = k0; kd[1] = k1; kd[2] = k2; kd[3] = k3;
    any_rel = 0;
    win = -1;
    for (int p = 0; p < NP; p++) begin
      acc_en[p]   = (kd[p] != K_IDLE);
      acc_wr[p]   = (kd[p] >= K_REL);
      acc_addr[p] = (kd[p] == K_PRD || kd[p] == K_WO) ? AW'(OA) : AW'(LA);
      acc_wbit[p] = (kd[p] == K_REL || kd[p] == K_WO);
      if (kd[p] == K_REL) any_rel = 1;
      if (kd[p] == K_LRD && win < 0) win = p;
    end
    for (int p = 0; p < NP; p++) begin
      ev[p] = (kd[p] == K_LRD || kd[p] == K_PRD) ? 1 : 0;
      ed[p] = 0;
      if (kd[p] == K_LRD) ed[p] = (m_held || p != win) ? 1 : 0;
    end
    // state update from start-of-cycle state
    if (m_held) begin
      if (any_rel) begin m_held = 0; m_owner = 0; end
    end else if (win >= 0) begin
      m_held = 1; m_owner = win;
    end
    @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      cmp({tag, " R9"}, $sformatf("rd_valid[%0d]", p), int'(rd_valid[p]), ev[p]);
      cmp(tag, $sformatf("rd_data[%0d]", p), int'(rd_data[p]), ed[p]);
    end
    cmp(tag, "lock_held", int'(lock_held), int'(m_held));
    cmp(tag, "lock_owner", int'(lock_owner), m_owner);
    acc_en = '0; acc_wr = '0; acc_addr = '0; acc_wbit = '0;
  endtask

  initial begin
    rst_n = 0;
    acc_en = '0; acc_wr = '0; acc_addr = '0; acc_wbit = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    cmp("R1", "lock_held", int'(lock_held), 0);
    cmp("R1", "lock_owner", int'(lock_owner), 0);
    cmp("R1", "rd_valid", int'(rd_valid), 0);
    cmp("R1", "rd_data", int'(rd_data), 0);
    rst_n = 1;
    @(negedge clk);
    cmp("R1", "lock_held after release of reset", int'(lock_held), 0);

    // directed sequence
    cyc(K_IDLE, K_IDLE, K_LRD, K_IDLE, "R2");       // port 2 claims
    cyc(K_LRD, K_IDLE, K_IDLE, K_LRD, "R3");        // held: both get 1
    cyc(K_WZ, K_WZ, K_WZ, K_WZ, "R6");              // write 0: no effect
    cyc(K_WO, K_PRD, K_WO, K_PRD, "R7");            // other address
    cyc(K_IDLE, K_REL, K_IDLE, K_IDLE, "R5");       // non-owner release
    cyc(K_PRD, K_LRD, K_IDLE, K_LRD, "R7 R4");      // plain read no claim; 1 wins
    cyc(K_REL, K_IDLE, K_LRD, K_IDLE, "R8");        // held: release + read
    cyc(K_LRD, K_REL, K_IDLE, K_IDLE, "R8");        // free: claim stands
    cyc(K_IDLE, K_IDLE, K_IDLE, K_IDLE, "R9");
    cyc(K_IDLE, K_IDLE, K_IDLE, K_REL, "R5");

    // exhaustive sweep: every per-port kind mix from every start state
    for (int s = 0; s < NP + 1; s++) begin
      for (int n = 0; n < 1296; n++) begin
        cyc(K_REL, K_IDLE, K_IDLE, K_IDLE, "R5");
        if (s > 0) begin
          case (s)
            1: cyc(K_LRD, K_IDLE, K_IDLE, K_IDLE, "R2");
            2: cyc(K_IDLE, K_LRD, K_IDLE, K_IDLE, "R2");
            3: cyc(K_IDLE, K_IDLE, K_LRD, K_IDLE, "R2");
            default: cyc(K_IDLE, K_IDLE, K_IDLE, K_LRD, "R2");
          endcase
        end
        cyc(n % 6, (n / 6) % 6, (n / 36) % 6, (n / 216) % 6, "R3 R4 R8");
      end
    end
    done = 1;
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end
endmodule